// File: doc/BRIEF.md
# Serial Channel Status Word with Write-One-to-Clear Flags

This block forms the 32-bit status word of one serial channel. The word holds four kinds of bits: the current levels of the four modem inputs, sticky flags that record any change on those inputs, a sticky receive-overrun flag, and the receive-data and transmit-empty conditions reported by the channel FIFOs. From the same state it drives one interrupt request line for the channel.

The modem pins arrive asynchronously and pass through two-flop synchronizers inside the block. A third register keeps the previous synchronized level, so an edge in either direction can be detected. The change flags and the overrun flag are cleared by a bus write that has a one in the flag's bit position. A zero in that position, or a one in any other position, changes nothing. Software can therefore read the word and write the same value back to acknowledge exactly the events it has just seen.

There is no data stream here. All ports are plain level signals, and the single-cycle write strobe carries no handshake.

Top module: `chan_status_reg`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, with all inputs low, the status word is zero and the interrupt output is low.
- R2: Bit 0 equals the receive-data-available input and bit 25 equals the transmit-empty input in the same cycle, with no register in between.
- R3: The synchronized level of each modem line appears at bit 3 for carrier detect, bit 4 for data-set-ready, bit 5 for clear-to-send and bit 6 for ring indicator, two clock edges after the pin changes.
- R4: A rising or a falling edge on a modem line sets that line's change flag three clock edges after the pin changes. The flags sit at bit 16 for data-set-ready, bit 17 for clear-to-send, bit 18 for carrier detect and bit 22 for ring indicator.
- R5: A flag stays set until a write with a one in its bit position clears it. A zero in that position leaves the flag set.
- R6: Writes have no effect on the live level bits (3 to 6), on bit 0 or on bit 25.
- R7: If a flag is being set and cleared on the same clock edge, the flag ends up set.
- R8: A one-cycle pulse on the overrun input sets bit 13. Bit 13 stays set until a write with a one in bit 13 clears it.
- R9: The interrupt output is high exactly when at least one of these holds: bit 0 is set and the receive interrupt enable is high; bit 25 is set and the transmit interrupt enable is high; any change flag is set and the modem interrupt enable is high.
- R10: Every bit of the status word not named in R2, R3, R4 or R8 reads as zero, including after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdm_pin | input | 4 | Modem inputs, asynchronous: [0] carrier detect, [1] data-set-ready, [2] clear-to-send, [3] ring indicator |
| rx_avail | input | 1 | Receive FIFO holds data |
| rx_overrun | input | 1 | One-cycle pulse when the receive FIFO overruns |
| tx_empty | input | 1 | Transmit FIFO is empty |
| en_rx_irq | input | 1 | Receive interrupt enable |
| en_tx_irq | input | 1 | Transmit interrupt enable |
| en_ms_irq | input | 1 | Modem-status interrupt enable |
| wr_en | input | 1 | Single-cycle write strobe for the status word |
| wr_data | input | 32 | Write data; a one clears the flag at that position |
| status | output | 32 | Channel status word |
| irq | output | 1 | Channel interrupt request |

## Verification
The FIFO condition bits and the interrupt output are combinational, so the bench checks them one time step after it drives the inputs, before the next clock edge. A live level bit is due after the second rising edge that follows a pin change, and a change flag after the third. The bench changes pins on a falling edge and samples on the following falling edges, and it checks that the bit is still clear one edge before it is due. For the set-versus-clear case, the bench places the clearing write on exactly the edge that sets the flag. Every write lasts one clock, so a flag that has been cleared is checked on the falling edge right after that write.

// File: rtl/chan_status_pkg.sv
package chan_status_pkg;
  localparam int STAT_W     = 32;
  localparam int NUM_MDM    = 4;
  localparam int SYNC_DEPTH = 2;

  localparam int BIT_RXDATA    = 0;
  localparam int BIT_LIVE_BASE = 3;
  localparam int BIT_OVERRUN   = 13;
  localparam int BIT_TXEMPTY   = 25;

  // modem line index: 0 carrier, 1 set-ready, 2 clear-to-send, 3 ring
  function automatic int chg_bit(input int line);
    case (line)
      0:       return 18;
      1:       return 16;
      2:       return 17;
      default: return 22;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] flag_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_MDM; i++) m[chg_bit(i)] = 1'b1;
    m[BIT_OVERRUN] = 1'b1;
    return m;
  endfunction

  function automatic logic [STAT_W-1:0] used_mask();
    logic [STAT_W-1:0] m;
    m = flag_mask();
    for (int i = 0; i < NUM_MDM; i++) m[BIT_LIVE_BASE + i] = 1'b1;
    m[BIT_RXDATA]  = 1'b1;
    m[BIT_TXEMPTY] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cs_sync_chain.sv
module cs_sync_chain #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else if (s == 0) stage[s] <= d_async;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stage[DEPTH-1];
endmodule

// File: rtl/cs_sticky_flag.sv
module cs_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic q
);
  // a new event on the clearing edge wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else q <= set_evt | (q & ~clr_req);
  end
endmodule

// File: rtl/chan_status_reg.sv
module chan_status_reg
  import chan_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_MDM-1:0] mdm_pin,
  input  logic              rx_avail,
  input  logic              rx_overrun,
  input  logic              tx_empty,
  input  logic              en_rx_irq,
  input  logic              en_tx_irq,
  input  logic              en_ms_irq,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam logic [STAT_W-1:0] CLR_MASK = flag_mask();

  logic [NUM_MDM-1:0] lvl_sync;
  logic [NUM_MDM-1:0] lvl_prev;
  logic [NUM_MDM-1:0] chg_q;
  logic [STAT_W-1:0]  clr_vec;
  logic               ovr_q;

  assign clr_vec = wr_en ? (wr_data & CLR_MASK) : '0;

  cs_sync_chain #(.WIDTH(NUM_MDM), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(mdm_pin), .q_sync(lvl_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= '0;
    else lvl_prev <= lvl_sync;
  end

  generate
    for (genvar g = 0; g < NUM_MDM; g++) begin : g_line
      cs_sticky_flag u_chg (
        .clk(clk), .rst_n(rst_n),
        .set_evt(lvl_sync[g] ^ lvl_prev[g]),
        .clr_req(clr_vec[chg_bit(g)]),
        .q(chg_q[g])
      );
    end
  endgenerate

  cs_sticky_flag u_ovr (
    .clk(clk), .rst_n(rst_n),
    .set_evt(rx_overrun),
    .clr_req(clr_vec[BIT_OVERRUN]),
    .q(ovr_q)
  );

  always_comb begin
    status = '0;
    status[BIT_RXDATA]  = rx_avail;
    status[BIT_TXEMPTY] = tx_empty;
    status[BIT_OVERRUN] = ovr_q;
    for (int i = 0; i < NUM_MDM; i++) begin
      status[BIT_LIVE_BASE + i] = lvl_sync[i];
      status[chg_bit(i)]        = chg_q[i];
    end
  end

  assign irq = (rx_avail & en_rx_irq) | (tx_empty & en_tx_irq) |
               ((|chg_q) & en_ms_irq);
endmodule

// File: rtl/chan_status_chk.sv
module chan_status_chk
  import chan_status_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [STAT_W-1:0] wr_data,
  input logic              en_rx_irq,
  input logic              en_tx_irq,
  input logic              en_ms_irq,
  input logic [STAT_W-1:0] status,
  input logic              irq
);
  localparam logic [STAT_W-1:0] USED = used_mask();

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~USED) == '0); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_rx_irq && !en_tx_irq && !en_ms_irq) |-> !irq); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[BIT_OVERRUN] && !(wr_en && wr_data[BIT_OVERRUN])) |=> status[BIT_OVERRUN]); // R8

  generate
    for (genvar g = 0; g < NUM_MDM; g++) begin : g_chk
      AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[chg_bit(g)] && !(wr_en && wr_data[chg_bit(g)])) |=> status[chg_bit(g)]); // R5

      AST_CHG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[chg_bit(g)]) |->
          ($past(status[BIT_LIVE_BASE+g]) != $past(status[BIT_LIVE_BASE+g], 2))); // R4
    end
  endgenerate
endmodule

bind chan_status_reg chan_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .en_rx_irq(en_rx_irq), .en_tx_irq(en_tx_irq), .en_ms_irq(en_ms_irq),
  .status(status), .irq(irq)
);

// File: tb/chan_status_reg_test.sv
module chan_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mdm_pin = '0;
  logic        rx_avail = 1'b0, rx_overrun = 1'b0, tx_empty = 1'b0;
  logic        en_rx_irq = 1'b0, en_tx_irq = 1'b0, en_ms_irq = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] status;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chan_status_reg uut (
    .clk(clk), .rst_n(rst_n), .mdm_pin(mdm_pin), .rx_avail(rx_avail),
    .rx_overrun(rx_overrun), .tx_empty(tx_empty), .en_rx_irq(en_rx_irq),
    .en_tx_irq(en_tx_irq), .en_ms_irq(en_ms_irq), .wr_en(wr_en),
    .wr_data(wr_data), .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 status in reset", status, 32'h0);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1);
    chk("R1 status after reset", status, 32'h0);
  endtask

  task automatic t_fifo_bits;
    rx_avail = 1'b1; #1;
    chk("R2 rx bit", status, 32'h0000_0001);
    tx_empty = 1'b1; rx_avail = 1'b0; #1;
    chk("R2 tx bit", status, 32'h0200_0000);
    cyc(1);
    wr(32'hFFFF_FFFF);
    chk("R6 tx bit after write", status, 32'h0200_0000);
    chk("R10 reserved after all-ones write", status, 32'h0200_0000);
    tx_empty = 1'b0; #1;
  endtask

  task automatic t_dcd_edges;
    mdm_pin[0] = 1'b1;
    cyc(1); chk("R3 live not yet", status, 32'h0);
    cyc(1); chk("R3 dcd live bit3", status, 32'h0000_0008);
    cyc(1); chk("R4 dcd rise flag bit18", status, 32'h0004_0008);
    wr(32'h0000_0000);
    chk("R5 zero write keeps flag", status, 32'h0004_0008);
    wr(32'h0000_0078);
    chk("R6 live bits ignore write", status, 32'h0004_0008);
    wr(32'h0004_0000);
    chk("R5 one write clears flag", status, 32'h0000_0008);
    mdm_pin[0] = 1'b0;
    cyc(3); chk("R4 dcd fall flag", status, 32'h0004_0000);
    wr(32'h0004_0000);
    chk("R5 clear after fall", status, 32'h0);
  endtask

  task automatic t_other_lines;
    mdm_pin = 4'b1110;
    cyc(3);
    chk("R4 dsr cts ri flags and R3 levels", status, 32'h0043_0070);
    wr(status);
    chk("R5 write-back clears only flags", status, 32'h0000_0070);
    mdm_pin = 4'b0000;
    cyc(3); wr(32'hFFFF_FFFF);
    chk("R5 all cleared", status, 32'h0);
  endtask

  task automatic t_set_wins;
    mdm_pin[1] = 1'b1; cyc(3);
    chk("R4 dsr flag bit16", status, 32'h0001_0010);
    mdm_pin[1] = 1'b0; cyc(2);
    wr(32'h0001_0000);
    chk("R7 set wins over clear", status, 32'h0001_0000);
    wr(32'h0001_0000);
    chk("R7 later clear works", status, 32'h0);
  endtask

  task automatic t_overrun;
    rx_overrun = 1'b1; cyc(1); rx_overrun = 1'b0;
    chk("R8 overrun set", status, 32'h0000_2000);
    cyc(4);
    chk("R8 overrun sticky", status, 32'h0000_2000);
    wr(32'h0000_2000);
    chk("R8 overrun cleared", status, 32'h0);
  endtask

  task automatic t_irq;
    rx_avail = 1'b1; #1;
    chk("R9 rx without enable", {31'b0, irq}, 32'h0);
    en_rx_irq = 1'b1; #1;
    chk("R9 rx with enable", {31'b0, irq}, 32'h1);
    rx_avail = 1'b0; tx_empty = 1'b1; #1;
    chk("R9 tx without enable", {31'b0, irq}, 32'h0);
    en_tx_irq = 1'b1; #1;
    chk("R9 tx with enable", {31'b0, irq}, 32'h1);
    tx_empty = 1'b0; cyc(1);
    mdm_pin[3] = 1'b1; cyc(3);
    chk("R9 ri flag, ms disabled", {31'b0, irq}, 32'h0);
    en_ms_irq = 1'b1; #1;
    chk("R9 ri flag, ms enabled", {31'b0, irq}, 32'h1);
    cyc(1); wr(32'h0040_0000);
    chk("R9 flag cleared drops irq", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_fifo_bits();
    t_dcd_edges();
    t_other_lines();
    t_set_wins();
    t_overrun();
    t_irq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule